// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects level-sensitive interrupt requests from up to sixteen on-chip sources and one 4-bit encoded external level. It presents to the processor the single most urgent request as a request flag, an event code and a 4-bit priority. Every source takes its priority from a 4-bit field. Several sources may point at the same field, which forms a group: for example all the events of one serial channel move together when that one field is rewritten.

Software sets the priorities through two narrow 16-bit registers and one wide 32-bit register, sixteen fields in all. It masks sources through a 32-bit mask that has one write address for setting bits and another for clearing them, so no read-modify-write is needed. A request goes out only when its priority is strictly above the processor's current level. The output is registered and follows the inputs with one cycle of delay.

Top module: `prio_intc`

## Requirements
- R1: After reset (active-low `rst_n`) every priority field and every mask bit is 0, and `irq_req`, `irq_code` and `irq_prio` are all 0.
- R2: Priority fields can be written and read back. Address 0 holds fields 0–3 and address 1 holds fields 4–7, each in bits [15:0]. Address 2 holds fields 8–15 in bits [31:0]. Field k of a register sits at bits [4k+3:4k]. On the 16-bit registers the upper 16 bits are ignored on write and read as zero. Addresses 5–7 ignore writes and read as zero.
- R3: Source i takes its priority from field `FIELD_MAP[4i+3:4i]`. With the default map, sources 0, 1, 8, 9, 10, 11, 12, 13, 14 and 15 use fields 0, 1, 4, 5, 6, 8, 9, 10, 11 and 15. Sources 2–3 share field 2, and sources 4–7 share field 3.
- R4: The event code of source i is 0x400 + 0x20·i.
- R5: A source competes only when all three of these hold: it is pending, its mask bit is 0, and its priority is strictly greater than `cpu_level`. A priority of 0 therefore never produces a request.
- R6: The competitor with the highest priority wins. On a tie the lowest source index wins, and the external level loses every tie to an internal source.
- R7: A write to address 3 sets every mask bit whose data bit is 1. A write to address 4 clears every mask bit whose data bit is 1. Reads at address 3 or 4 return the mask. Bit i masks source i, and bit 16 masks the external level.
- R8: An external level L below 15 requests with code 0x200 + 0x20·L and priority 15 − L. The value 15 means no request.
- R9: The outputs are registered: each cycle they reflect the inputs and registers of the previous cycle. When nothing wins, `irq_code` and `irq_prio` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| src_pend | input | 16 | Level-sensitive source requests |
| ext_level | input | 4 | Encoded external level, 15 = idle |
| cpu_level | input | 4 | Processor's current interrupt level |
| irq_req | output | 1 | A request is presented |
| irq_code | output | 12 | Event code of the winner |
| irq_prio | output | 4 | Priority of the winner |

## Verification
The bench targets grouped sources that share one field. A design that indexed fields by source number would give each member a different priority and break the group. Ties are tested both inside a group and between an internal source and the external level; a wrong comparison lets a higher index or the external input win. The case where the priority equals `cpu_level` is tested because an inclusive compare would let it through. The set and clear mask addresses are each driven with patterns that leave other bits alone, since a plain overwrite would unmask or mask unrelated sources. Writes with upper-half data to the 16-bit registers and writes to unused addresses must leave no trace in readback.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N_SRC = 16,
  parameter int CODE_W = 12,
  parameter logic [4*N_SRC-1:0] FIELD_MAP = 64'hFBA9_8654_3333_2210,
  parameter logic [CODE_W-1:0] VEC_BASE = 12'h400,
  parameter logic [CODE_W-1:0] EXT_BASE = 12'h200,
  parameter logic [CODE_W-1:0] VEC_STEP = 12'h020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [2:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic [N_SRC-1:0]  src_pend,
  input  logic [3:0]        ext_level,
  input  logic [3:0]        cpu_level,
  output logic              irq_req,
  output logic [CODE_W-1:0] irq_code,
  output logic [3:0]        irq_prio
);
  localparam int N_FLD = 16;
  localparam int N_CAND = N_SRC + 1;
  localparam int IDX_W = $clog2(N_CAND);
  localparam int EXT_BIT = N_SRC;
  localparam logic [3:0] EXT_IDLE = 4'hF;

  logic [15:0] prio_lo, prio_mid;
  logic [31:0] prio_wide, mask_q;
  logic [4*N_FLD-1:0] fields;
  logic [3:0] cand_prio [N_CAND];
  logic [N_CAND-1:0] cand;

  assign fields = {prio_wide, prio_mid, prio_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_lo   <= '0;
      prio_mid  <= '0;
      prio_wide <= '0;
      mask_q    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: prio_lo   <= wr_data[15:0];
        3'd1: prio_mid  <= wr_data[15:0];
        3'd2: prio_wide <= wr_data;
        3'd3: mask_q    <= mask_q | wr_data;
        3'd4: mask_q    <= mask_q & ~wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {16'h0, prio_lo};
      3'd1:    rd_data = {16'h0, prio_mid};
      3'd2:    rd_data = prio_wide;
      3'd3,
      3'd4:    rd_data = mask_q;
      default: rd_data = '0;
    endcase
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam int FLD = int'(FIELD_MAP[4*i +: 4]);
    assign cand_prio[i] = fields[4*FLD +: 4];
    assign cand[i] = src_pend[i] & ~mask_q[i] & (cand_prio[i] > cpu_level);
  end

  assign cand_prio[EXT_BIT] = EXT_IDLE - ext_level;
  assign cand[EXT_BIT] = (ext_level != EXT_IDLE) & ~mask_q[EXT_BIT] &
                         (cand_prio[EXT_BIT] > cpu_level);

  logic             win_found;
  logic [IDX_W-1:0] win_idx;
  logic [3:0]       win_prio;
  logic [CODE_W-1:0] win_code;

  always_comb begin
    win_found = 1'b0;
    win_idx   = '0;
    win_prio  = '0;
    for (int i = 0; i < N_CAND; i++) begin
      if (cand[i] && (!win_found || cand_prio[i] > win_prio)) begin
        win_found = 1'b1;
        win_idx   = IDX_W'(i);
        win_prio  = cand_prio[i];
      end
    end
    if (!win_found)
      win_code = '0;
    else if (win_idx == IDX_W'(EXT_BIT))
      win_code = EXT_BASE + VEC_STEP * CODE_W'(ext_level);
    else
      win_code = VEC_BASE + VEC_STEP * CODE_W'(win_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req  <= 1'b0;
      irq_code <= '0;
      irq_prio <= '0;
    end else begin
      irq_req  <= win_found;
      irq_code <= win_code;
      irq_prio <= win_prio;
    end
  end

  AST_REQ_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_prio > $past(cpu_level)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_code == '0 && irq_prio == '0)); // R9
  AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_code[4:0] == 5'd0); // R4
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd3) |=> ((mask_q & $past(wr_data)) == $past(wr_data))); // R7
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd4) |=> ((mask_q & $past(wr_data)) == '0)); // R7
  AST_EXT_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pend == '0 && ext_level == EXT_IDLE) |=> !irq_req); // R8
endmodule

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  localparam logic [63:0] MAP = 64'hFBA9_8654_3333_2210;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] src_pend = '0;
  logic [3:0] ext_level = 4'hF;
  logic [3:0] cpu_level = '0;
  logic irq_req;
  logic [11:0] irq_code;
  logic [3:0] irq_prio;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] b_lo = '0, b_mid = '0;
  logic [31:0] b_wide = '0, b_mask = '0;
  logic [16:0] exp_q [$];
  string tag_q [$];

  always #2 clk = ~clk;

  prio_intc u_prio_intc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .src_pend(src_pend), .ext_level(ext_level),
    .cpu_level(cpu_level), .irq_req(irq_req), .irq_code(irq_code), .irq_prio(irq_prio)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] model(input logic [15:0] p, input logic [3:0] e,
                                        input logic [3:0] c);
    logic [63:0] fld;
    logic found;
    logic [3:0] best, pr;
    logic [11:0] code;
    fld = {b_wide, b_mid, b_lo};
    found = 1'b0; best = '0; code = '0;
    for (int i = 0; i < 16; i++) begin
      pr = fld[4*MAP[4*i +: 4] +: 4];
      if (p[i] && !b_mask[i] && pr > c && (!found || pr > best)) begin
        found = 1'b1; best = pr; code = 12'h400 + 12'h020 * 12'(i);
      end
    end
    pr = 4'hF - e;
    if (e != 4'hF && !b_mask[16] && pr > c && (!found || pr > best)) begin
      found = 1'b1; best = pr; code = 12'h200 + 12'h020 * 12'(e);
    end
    return {found, code, best};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
    case (a)
      3'd0: b_lo = d[15:0];
      3'd1: b_mid = d[15:0];
      3'd2: b_wide = d;
      3'd3: b_mask = b_mask | d;
      3'd4: b_mask = b_mask & ~d;
      default: ;
    endcase
  endtask

  task automatic step(input logic [15:0] p, input logic [3:0] e, input logic [3:0] c,
                      input string tag);
    @(negedge clk);
    src_pend = p; ext_level = e; cpu_level = c;
    exp_q.push_back(model(p, e, c));
    tag_q.push_back(tag);
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_addr = a;
    #1 check(rd_data, exp, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [16:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({15'h0, irq_req, irq_code, irq_prio}, {15'h0, e}, t);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check({31'h0, irq_req}, 32'h0, "R1 req in reset");
    rd_check(3'd3, 32'h0, "R1 mask after reset");
    @(negedge clk) rst_n = 1'b1;
    rd_check(3'd2, 32'h0, "R1 wide prio after reset");
    check({20'h0, irq_code}, 32'h0, "R1 code after reset");

    step(16'hFFFF, 4'hF, 4'h0, "R5 all priorities zero");
    wr(3'd0, 32'hABCD_4321);
    rd_check(3'd0, 32'h0000_4321, "R2 narrow upper ignored");
    wr(3'd1, 32'h0000_8765);
    wr(3'd2, 32'h9A00_0B00);
    rd_check(3'd2, 32'h9A00_0B00, "R2 wide readback");
    wr(3'd6, 32'hFFFF_FFFF);
    rd_check(3'd6, 32'h0, "R2 unused address");
    rd_check(3'd1, 32'h0000_8765, "R2 unused write no effect");

    step(16'h0001, 4'hF, 4'h0, "R4 source 0 code");
    step(16'h0008, 4'hF, 4'h0, "R3 group member 3");
    step(16'h000C, 4'hF, 4'h0, "R6 tie in group");
    step(16'h00F0, 4'hF, 4'h0, "R3 serial group lowest");
    step(16'h0110, 4'hF, 4'h0, "R6 higher priority wins");
    step(16'h2000, 4'hF, 4'h0, "R4 source 13 code");
    step(16'h4000, 4'hF, 4'h0, "R5 zero field disabled");
    step(16'h2000, 4'hF, 4'hB, "R5 equal level blocked");
    step(16'h2000, 4'hF, 4'hA, "R5 level below passes");
    step(16'h0000, 4'hF, 4'h0, "R9 idle outputs zero");

    wr(3'd3, 32'h0000_2000);
    rd_check(3'd3, 32'h0000_2000, "R7 set address");
    rd_check(3'd4, 32'h0000_2000, "R7 clear address reads mask");
    step(16'h2100, 4'hF, 4'h0, "R7 masked source skipped");
    wr(3'd3, 32'h0001_0001);
    wr(3'd4, 32'h0000_2000);
    rd_check(3'd3, 32'h0001_0001, "R7 clear keeps others");
    step(16'h2100, 4'h0, 4'h0, "R7 external masked");
    wr(3'd4, 32'hFFFF_FFFF);

    step(16'h0000, 4'h0, 4'h0, "R8 level zero");
    step(16'h0000, 4'hE, 4'h0, "R8 level fourteen");
    step(16'h0000, 4'hF, 4'h0, "R8 idle level");
    step(16'h2000, 4'h4, 4'h0, "R6 external loses tie");
    step(16'h0000, 4'h4, 4'hB, "R8 external vs level");

    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 5) == 0)
        wr(3'($urandom_range(0, 7)), $urandom);
      step(16'($urandom), 4'($urandom), 4'($urandom_range(0, 6)), "R6 random mix");
    end
    repeat (3) @(negedge clk);
    rd_check(3'd0, {16'h0, b_lo}, "R2 final narrow readback");
    rd_check(3'd4, b_mask, "R7 final mask readback");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule